// File: doc/BRIEF.md
# I2C Master Start and Address Sequencer

This block is the master-side front end of an I2C controller. Firmware loads an address byte and asks for a Start. The block watches the open-drain SCL and SDA lines to learn whether the bus is in use. It waits until the bus has been free for a set number of bit ticks. It then issues a Start and shifts out the address byte, most significant bit first, and releases SDA for the ninth (acknowledge) bit. After that it holds SCL low and raises an interrupt until firmware writes the status/control register.

That register write decides what happens next. A write that ends the transfer produces a Stop. If a new Start request and a new address were lodged before that write, the Stop is followed by a Start after the minimum bus-free time, so messages can be chained. When the slave does not acknowledge the address, any next control write ends the transfer. If the block reads SDA low while it has released SDA for a 1 bit, it has lost arbitration. It stops driving SDA, finishes receiving the byte, and then stalls. When the local slave function is enabled, it also flags whether the winning master addressed this node.

Top module: `i2c_start_seq`

## Requirements
- R1: After reset, SCL and SDA are both released (`scl_oe` = 0, `sda_oe` = 0), and `irq`, `start_gen`, `lost_arb`, `addr_match`, `got_nack` and `bus_busy` are all 0.
- R2: `bus_busy` goes to 1 one clock after SDA is seen falling while SCL is high (a Start). It goes to 0 one clock after SDA is seen rising while SCL is high (a Stop). Both conditions are judged on the line levels of two successive clocks.
- R3: A Start request while the bus is busy leaves `start_gen` at 1 and both lines undriven. The Start is issued only after the bus has been free for at least FREE_TICKS ticks, where one tick is DIV clocks.
- R4: When a Start is issued, `start_gen` clears. The byte last written through `data_wr` goes out MSB first, one bit per four ticks, with SCL low for two ticks and high for two. SDA is released for the ninth bit.
- R5: `irq` rises only after the whole address byte has been clocked out (and, when arbitration held, after the acknowledge bit). While `irq` is 1, SCL is held low.
- R6: During a stall after an acknowledged address, a control write with `scr_nack` = 1 or `scr_xmit` = 0 produces a Stop. `irq` then clears, and both lines are released.
- R7: During a stall after an acknowledged address, a control write with `scr_xmit` = 1 and `scr_nack` = 0 has no effect: `irq` stays 1, SCL stays low and no Stop appears.
- R8: If `start_gen` is 1 when the ending control write arrives, the Stop is followed by a Start and by the newly loaded address. The Stop and the Start are at least (FREE_TICKS-1)·DIV clocks apart.
- R9: An address that is not acknowledged (SDA high on the ninth bit) sets `got_nack`. The next control write of any value then produces a Stop, followed by a Start if `start_gen` is 1.
- R10: If SDA reads low on a bit the block left high, `lost_arb` sets, `start_gen` clears and SDA is no longer driven. `irq` rises after the eighth bit and SCL is held low. The next control write releases both lines without issuing a Stop.
- R11: After a loss, `addr_match` is 1 exactly when `slave_en` = 1 and the upper seven received bits equal `own_addr`. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slave_en | input | 1 | Local slave function enabled |
| own_addr | input | 7 | This node's slave address |
| start_req | input | 1 | Pulse: set the Start request bit |
| data_wr | input | 1 | Pulse: load `data_in` as the address byte |
| data_in | input | 8 | Address byte (bit 0 is read/write) |
| scr_wr | input | 1 | Pulse: control register write |
| scr_xmit | input | 1 | Control write: continue transmitting |
| scr_nack | input | 1 | Control write: NACK (receiver ends transfer) |
| scl_in | input | 1 | Sampled SCL line level |
| sda_in | input | 1 | Sampled SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| start_gen | output | 1 | Start request pending |
| lost_arb | output | 1 | Arbitration lost on the last address |
| addr_match | output | 1 | Winning master addressed this node |
| got_nack | output | 1 | Last address was not acknowledged |
| bus_busy | output | 1 | Bus held between Start and Stop |
| irq | output | 1 | Event complete, bus stalled |

## Verification
The bench builds the block with DIV = 4 and FREE_TICKS = 3. At these values one address byte takes well under two hundred clocks, so queued Starts, chained Stop-then-Start, automatic Stops after a NACK, and both arbitration cases all fit in a short run. A free time of three ticks is long enough that the gap check between a Stop and the next Start can tell an enforced gap from a Start issued at once. The bench models the open-drain lines as a wired AND. It can add a competing master, an acknowledging slave and manual bus traffic, and it decodes Starts, Stops and bytes from the lines alone.

// File: rtl/i2c_start_seq.sv
module i2c_start_seq #(
  parameter int DIV        = 8,
  parameter int FREE_TICKS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       slave_en,
  input  logic [6:0] own_addr,
  input  logic       start_req,
  input  logic       data_wr,
  input  logic [7:0] data_in,
  input  logic       scr_wr,
  input  logic       scr_xmit,
  input  logic       scr_nack,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       scl_oe,
  output logic       sda_oe,
  output logic       start_gen,
  output logic       lost_arb,
  output logic       addr_match,
  output logic       got_nack,
  output logic       bus_busy,
  output logic       irq
);
  localparam int TW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int FW = $clog2(FREE_TICKS + 1);

  typedef enum logic [3:0] {IDLE, WAITF, ST_A, ST_B, SHIFT, STALL, STOP_A, STOP_B, STOP_C} st_t;
  st_t state;

  logic [TW-1:0] tcnt;
  logic [FW-1:0] fcnt;
  logic [1:0]    ph;
  logic [3:0]    idx;
  logic [7:0]    addr_r, rx;
  logic          scl_p, sda_p;

  wire tick      = tcnt == TW'(DIV - 1);
  wire start_det = scl_p & scl_in & sda_p & ~sda_in;
  wire stop_det  = scl_p & scl_in & ~sda_p & sda_in;
  wire free_ok   = fcnt == FW'(FREE_TICKS);
  wire cur       = addr_r[~idx[2:0]];
  wire lose      = (ph == 2'd2) && !idx[3] && cur && !lost_arb && !sda_in;
  wire end_req   = got_nack | scr_nack | ~scr_xmit;

  assign scl_oe = (state inside {ST_B, STALL, STOP_A}) || (state == SHIFT && !ph[1]);
  assign sda_oe = (state inside {ST_A, ST_B, STOP_A, STOP_B}) ||
                  (state == SHIFT && !idx[3] && !cur && !lost_arb);

  always_ff @(posedge clk) begin
    if (!rst_n) tcnt <= '0;
    else        tcnt <= tick ? '0 : tcnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_p <= 1'b1; sda_p <= 1'b1; bus_busy <= 1'b0; fcnt <= '0;
    end else begin
      scl_p <= scl_in;
      sda_p <= sda_in;
      if (start_det)     bus_busy <= 1'b1;
      else if (stop_det) bus_busy <= 1'b0;
      if (bus_busy || start_det) fcnt <= '0;
      else if (tick && !free_ok) fcnt <= fcnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= IDLE; ph <= '0; idx <= '0; addr_r <= '0; rx <= '0;
      start_gen <= 1'b0; lost_arb <= 1'b0; addr_match <= 1'b0;
      got_nack <= 1'b0; irq <= 1'b0;
    end else begin
      if (data_wr) addr_r <= data_in;
      case (state)
        IDLE:  if (start_gen) state <= WAITF;
        WAITF: if (tick && free_ok && !bus_busy) begin
          state <= ST_A; start_gen <= 1'b0; lost_arb <= 1'b0;
          addr_match <= 1'b0; got_nack <= 1'b0;
        end
        ST_A:  if (tick) state <= ST_B;
        ST_B:  if (tick) begin state <= SHIFT; ph <= '0; idx <= '0; end
        SHIFT: if (tick) begin
          ph <= ph + 1'b1;
          if (ph == 2'd2) begin
            rx <= {rx[6:0], sda_in};
            if (lose) begin lost_arb <= 1'b1; start_gen <= 1'b0; end
            if (idx == 4'd8) got_nack <= sda_in;
          end
          if (ph == 2'd3) begin
            if (idx == 4'd7 && lost_arb) begin
              state <= STALL; irq <= 1'b1;
              addr_match <= slave_en && (rx[7:1] == own_addr);
            end else if (idx == 4'd8) begin
              state <= STALL; irq <= 1'b1;
            end else idx <= idx + 4'd1;
          end
        end
        STALL: if (scr_wr) begin
          if (lost_arb)     begin state <= IDLE;   irq <= 1'b0; end
          else if (end_req) begin state <= STOP_A; irq <= 1'b0; end
        end
        STOP_A: if (tick) state <= STOP_B;
        STOP_B: if (tick) state <= STOP_C;
        STOP_C: if (tick) state <= IDLE;
        default: state <= IDLE;
      endcase
      if (start_req) start_gen <= 1'b1;
    end
  end

  AST_QUEUE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == WAITF && bus_busy) |=> start_gen); // R3
  AST_IRQ_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(state == SHIFT)); // R5
  AST_STALL_HOLDS_SCL: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !scr_wr) |=> scl_oe); // R5
  AST_LOSS_CLEARS_GEN: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(lost_arb) && !$past(start_req)) |-> !start_gen); // R10
  AST_MATCH_ONLY_LOST: assert property (@(posedge clk) disable iff (!rst_n)
    addr_match |-> lost_arb); // R11
  AST_NACK_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && got_nack && scr_wr) |=> !irq); // R9
endmodule

// File: tb/sim_i2c_start_seq.sv
`timescale 1ns/1ps
module sim_i2c_start_seq;
  localparam int DIV = 4, FREE = 3;

  logic clk = 0, rst_n = 0;
  logic slave_en = 0, start_req = 0, data_wr = 0, scr_wr = 0, scr_xmit = 0, scr_nack = 0;
  logic [6:0] own_addr = 0;
  logic [7:0] data_in = 0;
  logic scl_oe, sda_oe, start_gen, lost_arb, addr_match, got_nack, bus_busy, irq;
  logic man_sda = 0, pat_low = 0, ack_low = 0, other_en = 0, ack_en = 0;
  logic [7:0] other_b = 0;

  wire scl_l = ~scl_oe;
  wire sda_l = ~sda_oe & ~man_sda & ~pat_low & ~ack_low;

  i2c_start_seq #(.DIV(DIV), .FREE_TICKS(FREE)) u0 (
    .clk(clk), .rst_n(rst_n), .slave_en(slave_en), .own_addr(own_addr),
    .start_req(start_req), .data_wr(data_wr), .data_in(data_in),
    .scr_wr(scr_wr), .scr_xmit(scr_xmit), .scr_nack(scr_nack),
    .scl_in(scl_l), .sda_in(sda_l), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .start_gen(start_gen), .lost_arb(lost_arb), .addr_match(addr_match),
    .got_nack(got_nack), .bus_busy(bus_busy), .irq(irq));

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  int evlog[$];
  int ev_t[$];
  int cyc = 0, bcnt = 0, last_ack = 0, bitpos = -2;
  logic [7:0] sh = 0;
  logic busy_m = 0, scl_q = 1, sda_q = 1, scl_n = 1, sda_n = 1, irq_n = 0;

  // bus monitor and busy reference
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      busy_m <= 0; scl_q <= 1; sda_q <= 1; bcnt = 0;
    end else begin
      if (scl_q && scl_l && sda_q && !sda_l) begin
        busy_m <= 1; evlog.push_back(-1); ev_t.push_back(cyc); bcnt = 0;
      end else if (scl_q && scl_l && !sda_q && sda_l) begin
        busy_m <= 0; evlog.push_back(-2); ev_t.push_back(cyc);
      end
      if (!scl_q && scl_l) begin
        if (bcnt < 8) begin
          sh = {sh[6:0], sda_l}; bcnt++;
          if (bcnt == 8) begin evlog.push_back(int'(sh)); ev_t.push_back(cyc); end
        end else begin
          last_ack = int'(sda_l); bcnt++;
        end
      end
      scl_q <= scl_l; sda_q <= sda_l;
    end
  end

  // per-clock comparison and external bus agents
  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (bus_busy !== busy_m) begin
        errors++; $display("FAIL R2: bus_busy actual %0b expected %0b", bus_busy, busy_m);
      end
      if (irq && !irq_n) begin
        checks++;
        if (evlog.size() == 0 || evlog[evlog.size()-1] < 0) begin
          errors++; $display("FAIL R5: irq rose, last event actual %0d expected a byte",
                             evlog.size() == 0 ? -9 : evlog[evlog.size()-1]);
        end
      end
    end
    if (scl_n && scl_l && sda_n && !sda_l) bitpos = -1;
    else if (scl_n && !scl_l) bitpos++;
    pat_low = other_en && bitpos >= 0 && bitpos < 8 && !other_b[3'(7 - bitpos)];
    ack_low = ack_en && bitpos == 8;
    scl_n = scl_l; sda_n = sda_l; irq_n = irq;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++; $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n); repeat (n) @(negedge clk); endtask

  task automatic wr_data(input logic [7:0] v);
    @(negedge clk); data_in = v; data_wr = 1; @(negedge clk); data_wr = 0;
  endtask

  task automatic req_start;
    @(negedge clk); start_req = 1; @(negedge clk); start_req = 0;
  endtask

  task automatic scr(input logic x, input logic n);
    @(negedge clk); scr_xmit = x; scr_nack = n; scr_wr = 1; @(negedge clk); scr_wr = 0;
  endtask

  task automatic wait_irq(input string tag);
    int n = 0;
    while (!irq && n < 5000) begin @(negedge clk); n++; end
    chk(tag, int'(irq), 1);
  endtask

  task automatic ext_stop;
    man_sda = 1; wait_n(6); man_sda = 0; wait_n(30);
  endtask

  function automatic int ev(input int k); return evlog[evlog.size()-1-k]; endfunction
  function automatic int gap_last(input int k);
    return ev_t[ev_t.size()-1-k] - ev_t[ev_t.size()-2-k];
  endfunction

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait_n(4); rst_n = 1; @(negedge clk);
    chk("R1 scl_oe", int'(scl_oe), 0); chk("R1 sda_oe", int'(sda_oe), 0);
    chk("R1 irq", int'(irq), 0); chk("R1 start_gen", int'(start_gen), 0);
    chk("R1 lost_arb", int'(lost_arb), 0); chk("R1 bus_busy", int'(bus_busy), 0);
    chk("R1 got_nack", int'(got_nack), 0); chk("R1 addr_match", int'(addr_match), 0);

    // acknowledged address
    ack_en = 1;
    wr_data(8'hA4); req_start; wait_irq("R5 irq after byte");
    chk("R4 start event", ev(1), -1); chk("R4 address byte", ev(0), 'hA4);
    chk("R4 start_gen cleared", int'(start_gen), 0); chk("R4 ack seen", last_ack, 0);
    chk("R5 scl held", int'(scl_oe), 1); chk("R2 busy", int'(bus_busy), 1);
    chk("R9 no nack", int'(got_nack), 0);

    // continue-transmit write is ignored
    scr(1, 0); wait_n(40);
    chk("R7 irq kept", int'(irq), 1); chk("R7 scl kept", int'(scl_oe), 1);
    chk("R7 no stop", ev(0), 'hA4);

    // receiver ends with NACK while a new Start is pending: chained
    wr_data(8'h91); req_start; scr(0, 1); wait_irq("R8 chained irq");
    chk("R8 stop", ev(2), -2); chk("R8 start", ev(1), -1); chk("R8 byte", ev(0), 'h91);
    chk("R8 free gap", int'(gap_last(1) >= (FREE-1)*DIV), 1);

    // transmitter ends: plain Stop
    scr(0, 0); wait_n(60);
    chk("R6 stop", ev(0), -2); chk("R6 irq clear", int'(irq), 0);
    chk("R6 scl free", int'(scl_oe), 0); chk("R6 sda free", int'(sda_oe), 0);
    chk("R2 idle", int'(bus_busy), 0);

    // NACKed address, automatic Stop plus chained Start
    ack_en = 0;
    wr_data(8'h3C); req_start; wait_irq("R9 irq");
    chk("R9 got_nack", int'(got_nack), 1); chk("R9 ack bit high", last_ack, 1);
    wr_data(8'h5A); req_start; scr(1, 0); wait_irq("R9 chain irq");
    chk("R9 auto stop", ev(2), -2); chk("R9 start", ev(1), -1); chk("R9 byte", ev(0), 'h5A);
    scr(1, 0); wait_n(60);
    chk("R9 auto stop only", ev(0), -2); chk("R9 irq clear", int'(irq), 0);

    // queued Start behind another master's traffic
    ack_en = 1;
    man_sda = 1; wait_n(4);
    wr_data(8'h66); req_start; wait_n(80);
    chk("R3 start_gen held", int'(start_gen), 1); chk("R3 sda idle", int'(sda_oe), 0);
    chk("R3 scl idle", int'(scl_oe), 0); chk("R3 no irq", int'(irq), 0);
    man_sda = 0; wait_irq("R3 irq");
    chk("R3 stop", ev(2), -2); chk("R3 start", ev(1), -1); chk("R3 byte", ev(0), 'h66);
    chk("R3 free gap", int'(gap_last(1) >= (FREE-1)*DIV), 1);
    scr(0, 0); wait_n(60);

    // arbitration lost, slave function off
    ack_en = 0; slave_en = 0; own_addr = 7'h20; other_b = 8'h40; other_en = 1;
    wr_data(8'hA4); req_start; wait_irq("R10 irq");
    chk("R10 lost", int'(lost_arb), 1); chk("R10 start_gen", int'(start_gen), 0);
    chk("R10 sda released", int'(sda_oe), 0); chk("R10 scl held", int'(scl_oe), 1);
    chk("R10 byte on bus", ev(0), 'h40); chk("R11 no match when off", int'(addr_match), 0);
    scr(0, 0); wait_n(10);
    chk("R10 scl free", int'(scl_oe), 0); chk("R10 sda free", int'(sda_oe), 0);
    chk("R10 no stop", ev(0), 'h40); chk("R10 irq clear", int'(irq), 0);
    other_en = 0; ext_stop;

    // arbitration lost, slave function on, matching address
    slave_en = 1; own_addr = 7'h22; other_b = 8'h44; other_en = 1;
    wr_data(8'hA4); req_start; wait_irq("R11 irq");
    chk("R11 lost", int'(lost_arb), 1); chk("R11 match", int'(addr_match), 1);
    scr(0, 0); other_en = 0; wait_n(10); ext_stop;

    // slave function on, other address
    own_addr = 7'h23; other_en = 1;
    wr_data(8'hA4); req_start; wait_irq("R11 irq 2");
    chk("R11 mismatch", int'(addr_match), 0); chk("R11 lost 2", int'(lost_arb), 1);
    scr(0, 0); other_en = 0; wait_n(10); ext_stop;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule